// File: doc/BRIEF.md
# Write-Only Serial Control Register Slave for an Echo Mixer

This block is the configuration front end of an audio echo and mixer chip. It listens on a two-wire serial bus (I2C, write transfers only), recognises its own fixed 7-bit device address, and then accepts a register index byte followed by one or more data bytes. The data land in four 8-bit control registers. Their packed fields are unpacked and driven straight to the audio datapath: output line mode, external key enable, two microphone gain codes, echo delay code, echo gain code and feedback gain code. A four-bit factory test field can be written and is stored, but the test outputs toward the datapath are held at zero.

The bus pins arrive unsynchronised and are oversampled by the system clock. Each pin passes through a synchronizer chain. START and STOP are found as SDA edges while SCL is high, and SCL rising and falling edges are found the same way. One state machine sequences a transfer through these states: ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_SUB, ST_SUB_ACK, ST_DATA, ST_DATA_ACK and ST_IGNORE. The transitions are:
- STOP goes to ST_IDLE from any state.
- START, including a repeated START, goes to ST_ADDR from any state.
- A completed byte moves the machine, on the next SCL falling edge, from ST_ADDR, ST_SUB or ST_DATA to the matching ACK state. If the address or index is rejected, it moves to ST_IGNORE instead.
- Each ACK state moves on at the SCL falling edge that ends the ninth clock, to ST_SUB, ST_DATA and ST_DATA respectively.

The acknowledge is an active-high pull-down request for an external open-drain SDA driver.

Top module: `echo_ctrl_i2c_slave`

## Requirements
- R1: After reset every control output is 0 and `sda_pull_o` is 0. Reset applies asynchronously and is active low.
- R2: Only the address byte 0x38 (device address 0011100 followed by a 0 write bit) is acknowledged. Any other address byte, including 0x39 with the read bit set, is not acknowledged, and no later byte of that transfer is acknowledged or stored.
- R3: Bytes are received MSB first, one bit per SCL rising edge. The acknowledge pull-down is asserted only after an SCL falling edge, and it is held through the ninth SCL clock of the byte.
- R4: Register indices 0x01 to 0x04 are acknowledged. Any other index byte (for example 0x00 or 0x05) is not acknowledged, and the data bytes that follow are not acknowledged and change no output.
- R5: Index 0x01 drives `line_sel` from D7..D5, `key_en` from D4 and `mic1_gain` from D2..D0. D3 has no effect.
- R6: Index 0x02 drives `mic2_gain` from D6..D4. D3..D0 are the test field: they are stored, but `test_ctl` stays 0 whatever is written.
- R7: Index 0x03 drives `delay_code` from D6..D4 and `echo_gain` from D2..D0.
- R8: Index 0x04 drives `fb_gain` from D6..D4.
- R9: A START or STOP that arrives before the eighth data bit leaves every register unchanged. After a repeated START, a complete new transfer is accepted.
- R10: A register changes only when a complete data byte is acknowledged. Further data bytes in the same transfer are acknowledged and overwrite the same register.
- R11: SDA is sampled only at SCL rising edges. SDA changes while SCL is low do not alter the received byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock pin level |
| sda_i | input | 1 | Serial data pin level (wired bus) |
| sda_pull_o | output | 1 | 1 requests the open-drain driver to pull SDA low |
| line_sel | output | 3 | Line output mode code |
| key_en | output | 1 | External key control enable |
| mic1_gain | output | 3 | Microphone 1 gain code |
| mic2_gain | output | 3 | Microphone 2 gain code |
| test_ctl | output | 4 | Test controls, held at 0 |
| delay_code | output | 3 | Echo delay code |
| echo_gain | output | 3 | Echo output gain code |
| fb_gain | output | 3 | Echo feedback gain code |

## Verification
The assertions assume that each SCL level and each SDA level is held for several system clocks, so that the synchronizers see every edge. They also assume that SDA changes while SCL is high only to signal START or STOP. The bench master holds each SCL phase for twelve clocks and changes SDA only six clocks into the low phase. That is after the slave has released its acknowledge, so every check sees a clean, legal bus. Where the bench breaks the protocol on purpose, it does so with a STOP or repeated START in mid-byte and with SDA wobbling during SCL low. None of these patterns breaks those assumptions.

// File: rtl/echo_ctrl_pkg.sv
package echo_ctrl_pkg;

    localparam int unsigned REG_W    = 8;
    localparam int unsigned NUM_REGS = 4;
    localparam int unsigned IDX_W    = $clog2(NUM_REGS);
    localparam int unsigned CNT_W    = $clog2(REG_W);

    localparam logic [6:0] DEF_DEV_ADDR = 7'b0011100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_IGNORE
    } rx_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_bit,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    // Synchronizer chains plus one extra stage that holds the previous level.
    logic [SYNC_STAGES:0] scl_pipe;
    logic [SYNC_STAGES:0] sda_pipe;
    logic scl_now, scl_prev, sda_now, sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-1:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-1:0], sda_i};
        end
    end

    assign scl_now  = scl_pipe[SYNC_STAGES-1];
    assign scl_prev = scl_pipe[SYNC_STAGES];
    assign sda_now  = sda_pipe[SYNC_STAGES-1];
    assign sda_prev = sda_pipe[SYNC_STAGES];

    assign sda_bit   = sda_now;
    assign scl_rise  = scl_now & ~scl_prev;
    assign scl_fall  = ~scl_now & scl_prev;
    assign start_det = scl_now & scl_prev & sda_prev & ~sda_now;
    assign stop_det  = scl_now & scl_prev & ~sda_prev & sda_now;

endmodule

// File: rtl/i2c_rx_fsm.sv
module i2c_rx_fsm
    import echo_ctrl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = DEF_DEV_ADDR
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_bit,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    output logic             sda_pull,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [REG_W-1:0] wr_data
);

    rx_state_e        state, state_d;
    logic [CNT_W-1:0] bit_cnt;
    logic [REG_W-1:0] shreg;
    logic             byte_full;
    logic [IDX_W-1:0] sub_idx;
    logic             addr_ok, sub_ok, rx_phase, byte_end;

    assign addr_ok  = (shreg == {DEV_ADDR, 1'b0});
    assign sub_ok   = (shreg != '0) && (int'(shreg) <= int'(NUM_REGS));
    assign rx_phase = (state == ST_ADDR) || (state == ST_SUB) || (state == ST_DATA);
    assign byte_end = byte_full && scl_fall;

    // Next-state logic
    always_comb begin
        state_d = state;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR:     if (byte_end) state_d = addr_ok ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall) state_d = ST_SUB;
                ST_SUB:      if (byte_end) state_d = sub_ok ? ST_SUB_ACK : ST_IGNORE;
                ST_SUB_ACK:  if (scl_fall) state_d = ST_DATA;
                ST_DATA:     if (byte_end) state_d = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall) state_d = ST_DATA;
                ST_IGNORE:   state_d = ST_IGNORE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // Byte assembly and index capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            byte_full <= 1'b0;
            sub_idx   <= '0;
        end else if (start_det || stop_det) begin
            bit_cnt   <= '0;
            byte_full <= 1'b0;
        end else begin
            if (scl_rise && rx_phase) begin
                shreg   <= {shreg[REG_W-2:0], sda_bit};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CNT_W'(REG_W - 1)) byte_full <= 1'b1;
            end
            if (byte_end) byte_full <= 1'b0;
            if ((state == ST_SUB) && byte_end && sub_ok)
                sub_idx <= IDX_W'(shreg - 8'd1);
        end
    end

    // Outputs
    always_comb begin
        sda_pull = (state == ST_ADDR_ACK) || (state == ST_SUB_ACK) || (state == ST_DATA_ACK);
        wr_en    = (state == ST_DATA) && byte_end && !start_det && !stop_det;
        wr_idx   = sub_idx;
        wr_data  = shreg;
    end

    // R3: acknowledge pull-down begins only right after an SCL falling edge
    p_ack_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> $past(scl_fall));

    // R9: a START is never followed by a register write in the next cycle
    p_start_blocks_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !wr_en);

    // R2: a rejected transfer leaves ST_IGNORE only through START or STOP
    p_ignore_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |=> (state == ST_IGNORE || state == ST_IDLE || state == ST_ADDR));

endmodule

// File: rtl/echo_ctrl_regfile.sv
module echo_ctrl_regfile
    import echo_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [REG_W-1:0] wr_data,
    output logic [2:0]       line_sel,
    output logic             key_en,
    output logic [2:0]       mic1_gain,
    output logic [2:0]       mic2_gain,
    output logic [3:0]       test_ctl,
    output logic [2:0]       delay_code,
    output logic [2:0]       echo_gain,
    output logic [2:0]       fb_gain
);

    logic [REG_W-1:0]          ctl_reg [NUM_REGS];
    logic [NUM_REGS*REG_W-1:0] ctl_flat;

    for (genvar i = 0; i < int'(NUM_REGS); i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             ctl_reg[i] <= '0;
            else if (wr_en && wr_idx == IDX_W'(i))  ctl_reg[i] <= wr_data;
        end
        assign ctl_flat[i*REG_W +: REG_W] = ctl_reg[i];
    end

    // Field decode
    assign line_sel   = ctl_reg[0][7:5];
    assign key_en     = ctl_reg[0][4];
    assign mic1_gain  = ctl_reg[0][2:0];
    assign mic2_gain  = ctl_reg[1][6:4];
    assign test_ctl   = '0;
    assign delay_code = ctl_reg[2][6:4];
    assign echo_gain  = ctl_reg[2][2:0];
    assign fb_gain    = ctl_reg[3][6:4];

    logic unused_bits;
    assign unused_bits = ^{ctl_reg[0][3], ctl_reg[1][7], ctl_reg[1][3:0],
                           ctl_reg[2][7], ctl_reg[2][3], ctl_reg[3][7], ctl_reg[3][3:0]};

    // R10: register contents move only on a write strobe
    p_hold_without_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctl_flat));

endmodule

// File: rtl/echo_ctrl_i2c_slave.sv
module echo_ctrl_i2c_slave
    import echo_ctrl_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [6:0]  DEV_ADDR    = DEF_DEV_ADDR
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    output logic [2:0] line_sel,
    output logic       key_en,
    output logic [2:0] mic1_gain,
    output logic [2:0] mic2_gain,
    output logic [3:0] test_ctl,
    output logic [2:0] delay_code,
    output logic [2:0] echo_gain,
    output logic [2:0] fb_gain
);

    logic             sda_bit, scl_rise, scl_fall, start_det, stop_det;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [REG_W-1:0] wr_data;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_bit   (sda_bit),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_rx_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_bit   (sda_bit),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_pull  (sda_pull_o),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data)
    );

    echo_ctrl_regfile u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .line_sel   (line_sel),
        .key_en     (key_en),
        .mic1_gain  (mic1_gain),
        .mic2_gain  (mic2_gain),
        .test_ctl   (test_ctl),
        .delay_code (delay_code),
        .echo_gain  (echo_gain),
        .fb_gain    (fb_gain)
    );

endmodule

// File: tb/echo_ctrl_i2c_slave_test.sv
module echo_ctrl_i2c_slave_test;

    localparam int Q = 6;
    localparam int NVEC = 10;
    // {address byte, index byte, data byte}
    localparam logic [23:0] VEC [NVEC] = '{
        24'h38_01_B5, 24'h38_02_7F, 24'h38_03_53, 24'h38_04_60,
        24'h3A_01_FF, 24'h39_02_FF, 24'h38_05_FF, 24'h38_00_FF,
        24'h38_01_4A, 24'h38_03_A4
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_bus;
    logic sda_pull_o, key_en;
    logic [2:0] line_sel, mic1_gain, mic2_gain, delay_code, echo_gain, fb_gain;
    logic [3:0] test_ctl;
    logic [7:0] sh [4];
    int tests = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;
    assign sda_bus = sda_m & ~sda_pull_o;

    echo_ctrl_i2c_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_pull_o(sda_pull_o), .line_sel(line_sel), .key_en(key_en),
        .mic1_gain(mic1_gain), .mic2_gain(mic2_gain), .test_ctl(test_ctl),
        .delay_code(delay_code), .echo_gain(echo_gain), .fb_gain(fb_gain)
    );

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] obs();
        return {9'd0, line_sel, key_en, mic1_gain, mic2_gain, test_ctl,
                delay_code, echo_gain, fb_gain};
    endfunction

    // Expected outputs from the field positions listed in R5..R8 (test field always 0, R6)
    function automatic logic [31:0] expv();
        return {9'd0, sh[0][7:5], sh[0][4], sh[0][2:0], sh[1][6:4], 4'b0000,
                sh[2][6:4], sh[2][2:0], sh[3][6:4]};
    endfunction

    task automatic i2c_start();
        sda_m = 1'b1; wclk(Q); scl_m = 1'b1; wclk(Q);
        sda_m = 1'b0; wclk(Q); scl_m = 1'b0; wclk(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wclk(Q); scl_m = 1'b1; wclk(2*Q);
        sda_m = 1'b1; wclk(2*Q);
    endtask

    task automatic send_bit(input logic b, input bit wobble);
        if (wobble) begin
            sda_m = ~b; wclk(2); sda_m = b; wclk(2); sda_m = ~b; wclk(2);
        end
        sda_m = b; wclk(Q); scl_m = 1'b1; wclk(2*Q); scl_m = 1'b0; wclk(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit wobble, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i], wobble);
        sda_m = 1'b1; wclk(Q); scl_m = 1'b1; wclk(Q);
        ack = ~sda_bus;
        wclk(Q); scl_m = 1'b0; wclk(Q);
    endtask

    initial begin
        logic a1, a2, a3, e1, e2;
        for (int k = 0; k < 4; k++) sh[k] = 8'h00;
        wclk(5);
        // R1: reset state
        check("R1 outputs after reset", obs(), 32'h0);
        check("R1 sda_pull after reset", {31'd0, sda_pull_o}, 32'h0);
        rst_n = 1'b1;
        wclk(5);

        // Table-driven transfers: R2, R4, R5, R6, R7, R8
        for (int v = 0; v < NVEC; v++) begin
            i2c_start();
            send_byte(VEC[v][23:16], 1'b0, a1);
            send_byte(VEC[v][15:8], 1'b0, a2);
            send_byte(VEC[v][7:0], 1'b0, a3);
            i2c_stop();
            e1 = (VEC[v][23:16] == 8'h38);
            e2 = e1 && (VEC[v][15:8] >= 8'h01) && (VEC[v][15:8] <= 8'h04);
            if (e2) sh[VEC[v][9:8] - 2'd1] = VEC[v][7:0];
            check($sformatf("R2 address ack vec %0d", v), {31'd0, a1}, {31'd0, e1});
            check($sformatf("R4 index ack vec %0d", v), {31'd0, a2}, {31'd0, e2});
            check($sformatf("R10 data ack vec %0d", v), {31'd0, a3}, {31'd0, e2});
            check($sformatf("R5 R6 R7 R8 fields vec %0d", v), obs(), expv());
        end
        check("R6 test outputs held low", {28'd0, test_ctl}, 32'h0);

        // R9: STOP in the middle of a data byte
        i2c_start();
        send_byte(8'h38, 1'b0, a1);
        send_byte(8'h01, 1'b0, a2);
        for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0);
        i2c_stop();
        check("R9 stop mid-byte leaves registers", obs(), expv());

        // R9: repeated START mid-byte, then a full new transfer
        i2c_start();
        send_byte(8'h38, 1'b0, a1);
        send_byte(8'h02, 1'b0, a2);
        for (int i = 0; i < 3; i++) send_bit(1'b0, 1'b0);
        check("R9 partial byte before restart", obs(), expv());
        i2c_start();
        send_byte(8'h38, 1'b0, a1);
        send_byte(8'h02, 1'b0, a2);
        send_byte(8'h25, 1'b0, a3);
        i2c_stop();
        sh[1] = 8'h25;
        check("R9 transfer after repeated start ack", {31'd0, a3}, 32'h1);
        check("R9 transfer after repeated start", obs(), expv());

        // R10: two data bytes in one transfer rewrite the same register
        i2c_start();
        send_byte(8'h38, 1'b0, a1);
        send_byte(8'h03, 1'b0, a2);
        send_byte(8'h11, 1'b0, a3);
        sh[2] = 8'h11;
        check("R10 first data byte applied", obs(), expv());
        send_byte(8'h62, 1'b0, a3);
        i2c_stop();
        sh[2] = 8'h62;
        check("R10 second data byte ack", {31'd0, a3}, 32'h1);
        check("R10 second data byte overwrites", obs(), expv());

        // R11: SDA wobble while SCL low does not change the byte
        i2c_start();
        send_byte(8'h38, 1'b1, a1);
        send_byte(8'h04, 1'b1, a2);
        send_byte(8'h30, 1'b1, a3);
        i2c_stop();
        sh[3] = 8'h30;
        check("R11 wobble acks", {29'd0, a1, a2, a3}, 32'h7);
        check("R11 wobble data", obs(), expv());

        // R3: no pull-down while the bus is idle
        check("R3 pull released when idle", {31'd0, sda_pull_o}, 32'h0);

        // R1: reset in the middle of operation
        rst_n = 1'b0;
        wclk(3);
        for (int k = 0; k < 4; k++) sh[k] = 8'h00;
        check("R1 outputs after second reset", obs(), expv());
        rst_n = 1'b1;
        wclk(3);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule